// File: doc/BRIEF.md
# Deep Sleep Wake-Up Controller

This block supervises the deepest low-power state of a small core. Software requests entry with a one-cycle strobe. The block then raises a deep-sleep-enable bit and pulses a clear for any interrupt that was pending at that moment. While the core sleeps, the block watches five wake sources: a power-on event, a deep-sleep watchdog timeout, a real-time clock alarm gated by its enable, an active-low master reset pin, and an external interrupt pin.

The first wake event ends the sleep. The enable bit clears itself, and a one-hot-per-source record latches every source that fired in that cycle. A sticky exit flag is set, and a core reset request is held for a fixed number of cycles. Any wake events during that reset window are dropped.

The external pin passes through a two-flop synchronizer. Its polarity selects which level wakes the core. It wakes the core only on a change to that level during sleep, and only if it was enabled when sleep began. A brown-out seen during sleep is recorded in its own status bit.

Top module: `ds_wake_top`

## Requirements
- R1: A `sleepReq` pulse while awake and not in the reset window sets `dsEnable` at the next clock edge. In that same cycle `pendClr` is high for exactly one cycle.
- R2: While asleep, any of `porEvent`=1, `wdtTimeout`=1, `rtcAlarm`=1 with `rtcEnable`=1, or `mclrN`=0, sampled at a clock edge, causes an exit at that edge. After the edge `dsEnable`=0, `exitFlag`=1 and `coreRst`=1.
- R3: An `rtcAlarm` with `rtcEnable`=0 does not wake the core.
- R4: The external pin wakes the core only on a transition, seen after two synchronizer flops, to the level given by `extPolarity` (1 means high wakes) while asleep. The wake-up occurs at the third clock edge after the pin changes. A level that is already asserted at entry does not wake the core. `extEnable` is sampled at entry, and later changes have no effect.
- R5: `wakeSrc` latches every source that fired in the exit cycle: bit 0 power-on, bit 1 watchdog, bit 2 clock alarm, bit 3 master reset pin, bit 4 external pin.
- R6: `coreRst` stays high for exactly `RST_CYCLES` consecutive cycles after an exit. Wake events during that window leave `wakeSrc` unchanged.
- R7: `exitFlag`, `wakeSrc` and `dsBor` keep their values while awake until a `statusClr` pulse, which clears all three at the next edge.
- R8: A `brownOut` pulse while asleep sets `dsBor` and does not wake the core. A `brownOut` pulse while awake has no effect.
- R9: After reset every output is 0.
- R10: `sleepReq` is ignored during the reset window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low cold reset of the controller |
| sleepReq | input | 1 | Deep sleep entry strobe |
| statusClr | input | 1 | Clears exit flag, wake record and brown-out bit |
| porEvent | input | 1 | Power-on event (digital model) |
| wdtTimeout | input | 1 | Deep-sleep watchdog timeout |
| rtcAlarm | input | 1 | Real-time clock alarm |
| rtcEnable | input | 1 | Real-time clock enabled |
| mclrN | input | 1 | Master reset pin, active low |
| extPin | input | 1 | Asynchronous external interrupt pin |
| extPolarity | input | 1 | Wake level of the external pin |
| extEnable | input | 1 | External pin wake enable, sampled at entry |
| brownOut | input | 1 | Deep-sleep brown-out event (digital model) |
| dsEnable | output | 1 | Deep sleep active; clears itself on wake |
| pendClr | output | 1 | One-cycle clear of pending interrupts at entry |
| exitFlag | output | 1 | Sticky deep-sleep-exit flag |
| wakeSrc | output | 5 | Wake source record |
| dsBor | output | 1 | Brown-out during deep sleep seen |
| coreRst | output | 1 | Reset request to the core during the post-exit window |

## Verification
The state of interest here is the sleep/restart state and the reset-window counter. If the state machine is stuck asleep, `dsEnable` stays high and `coreRst` never rises after a valid source fires. A miscounting window shows as a `coreRst` run of the wrong length, visible within `RST_CYCLES`+1 cycles of the exit. A wrong synchronizer or edge history makes an external wake arrive one edge early or late, or appear from a level that was held at entry. A missing exit capture shows as a `wakeSrc` that does not match the set of sources applied in the exit cycle.

// File: rtl/ds_wake_pkg.sv
package ds_wake_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_POR = 0;
  localparam int SRC_WDT = 1;
  localparam int SRC_RTC = 2;
  localparam int SRC_MCLR = 3;
  localparam int SRC_EXT = 4;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ASLEEP  = 2'd1,
    ST_RESTART = 2'd2
  } dsState_t;

  typedef struct packed {
    logic enterSleep;
    logic asleep;
    logic takeWake;
    logic clearStatus;
  } dsStrobe_t;
endpackage

// File: rtl/ds_wake_ctrl.sv
module ds_wake_ctrl
  import ds_wake_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepReq,
  input  logic      statusClr,
  input  logic      anyWake,
  output dsStrobe_t strobe,
  output logic      coreRst
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

  dsState_t stateQ;
  logic [CNT_W-1:0] cntQ;

  always_comb begin
    strobe.enterSleep  = (stateQ == ST_AWAKE) && sleepReq;
    strobe.asleep      = (stateQ == ST_ASLEEP);
    strobe.takeWake    = (stateQ == ST_ASLEEP) && anyWake;
    strobe.clearStatus = (stateQ == ST_AWAKE) && statusClr;
    coreRst            = (stateQ == ST_RESTART);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_AWAKE;
      cntQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_AWAKE: begin
          if (sleepReq) stateQ <= ST_ASLEEP;
        end
        ST_ASLEEP: begin
          if (anyWake) begin
            stateQ <= ST_RESTART;
            cntQ   <= '0;
          end
        end
        ST_RESTART: begin
          if (cntQ == CNT_LAST) stateQ <= ST_AWAKE;
          else                  cntQ   <= cntQ + 1'b1;
        end
        default: stateQ <= ST_AWAKE;
      endcase
    end
  end
endmodule

// File: rtl/ds_wake_dp.sv
module ds_wake_dp
  import ds_wake_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dsStrobe_t          strobe,
  input  logic               porEvent,
  input  logic               wdtTimeout,
  input  logic               rtcAlarm,
  input  logic               rtcEnable,
  input  logic               mclrN,
  input  logic               extPin,
  input  logic               extPolarity,
  input  logic               extEnable,
  input  logic               brownOut,
  output logic               anyWake,
  output logic               dsEnable,
  output logic               pendClr,
  output logic               exitFlag,
  output logic [NUM_SRC-1:0] wakeSrc,
  output logic               dsBor
);
  logic [1:0] syncQ;
  logic       prevQ;
  logic       extArmQ;
  logic       extHit;
  logic [NUM_SRC-1:0] wakeVec;

  // Two-flop synchronizer followed by one stage of edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], extPin};
      prevQ <= syncQ[1];
    end
  end

  // Edge into the wake level; a level held since entry never qualifies
  assign extHit = (syncQ[1] == extPolarity) && (prevQ != extPolarity);

  always_comb begin
    wakeVec           = '0;
    wakeVec[SRC_POR]  = porEvent;
    wakeVec[SRC_WDT]  = wdtTimeout;
    wakeVec[SRC_RTC]  = rtcAlarm && rtcEnable;
    wakeVec[SRC_MCLR] = !mclrN;
    wakeVec[SRC_EXT]  = extHit && extArmQ;
    anyWake           = |wakeVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extArmQ  <= 1'b0;
      dsEnable <= 1'b0;
      pendClr  <= 1'b0;
      exitFlag <= 1'b0;
      wakeSrc  <= '0;
      dsBor    <= 1'b0;
    end else begin
      pendClr <= strobe.enterSleep;
      if (strobe.enterSleep) begin
        extArmQ  <= extEnable;
        dsEnable <= 1'b1;
      end
      if (strobe.takeWake) begin
        dsEnable <= 1'b0;
        exitFlag <= 1'b1;
        wakeSrc  <= wakeVec;
      end else if (strobe.clearStatus) begin
        exitFlag <= 1'b0;
        wakeSrc  <= '0;
      end
      if (strobe.asleep && brownOut) dsBor <= 1'b1;
      else if (strobe.clearStatus)   dsBor <= 1'b0;
    end
  end
endmodule

// File: rtl/ds_wake_top.sv
module ds_wake_top
  import ds_wake_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepReq,
  input  logic               statusClr,
  input  logic               porEvent,
  input  logic               wdtTimeout,
  input  logic               rtcAlarm,
  input  logic               rtcEnable,
  input  logic               mclrN,
  input  logic               extPin,
  input  logic               extPolarity,
  input  logic               extEnable,
  input  logic               brownOut,
  output logic               dsEnable,
  output logic               pendClr,
  output logic               exitFlag,
  output logic [NUM_SRC-1:0] wakeSrc,
  output logic               dsBor,
  output logic               coreRst
);
  dsStrobe_t strobe;
  logic      anyWake;

  ds_wake_ctrl #(.RST_CYCLES(RST_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .statusClr(statusClr),
    .anyWake(anyWake), .strobe(strobe), .coreRst(coreRst)
  );

  ds_wake_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .porEvent(porEvent), .wdtTimeout(wdtTimeout), .rtcAlarm(rtcAlarm),
    .rtcEnable(rtcEnable), .mclrN(mclrN), .extPin(extPin),
    .extPolarity(extPolarity), .extEnable(extEnable), .brownOut(brownOut),
    .anyWake(anyWake), .dsEnable(dsEnable), .pendClr(pendClr),
    .exitFlag(exitFlag), .wakeSrc(wakeSrc), .dsBor(dsBor)
  );
endmodule

// File: rtl/ds_wake_chk.sv
module ds_wake_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       statusClr,
  input logic       dsEnable,
  input logic       pendClr,
  input logic       exitFlag,
  input logic [4:0] wakeSrc,
  input logic       coreRst
);
  localparam int LW = $clog2(RST_CYCLES + 2);
  logic [LW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runLen <= '0;
    else if (!coreRst) runLen <= '0;
    else               runLen <= runLen + 1'b1;
  end

  a_r1_pend_with_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dsEnable) |-> pendClr);
  a_r1_pend_single: assert property (@(posedge clk) disable iff (!rstN)
    pendClr |=> !pendClr);
  a_r2_exit_marks: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dsEnable) |-> (coreRst && exitFlag && (wakeSrc != 5'd0)));
  a_r6_window_max: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |-> (int'(runLen) < RST_CYCLES));
  a_r6_window_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreRst) |-> (int'($past(runLen)) == RST_CYCLES - 1));
  a_r6_record_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (coreRst && $past(coreRst)) |-> $stable(wakeSrc));
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(exitFlag) |-> $past(statusClr));
  a_r10_no_entry_in_window: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |=> !$rose(dsEnable));
  a_r2_sleep_excludes_reset: assert property (@(posedge clk) disable iff (!rstN)
    dsEnable |-> !coreRst);
endmodule

bind ds_wake_top ds_wake_chk #(.RST_CYCLES(RST_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .statusClr(statusClr), .dsEnable(dsEnable),
  .pendClr(pendClr), .exitFlag(exitFlag), .wakeSrc(wakeSrc), .coreRst(coreRst)
);

// File: tb/ds_wake_top_tb_top.sv
module ds_wake_top_tb_top;
  localparam int RST = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, sleepReq, statusClr, porEvent, wdtTimeout, rtcAlarm, rtcEnable;
  logic mclrN, extPin, extPolarity, extEnable, brownOut;
  logic dsEnable, pendClr, exitFlag, dsBor, coreRst;
  logic [4:0] wakeSrc;

  int vecs = 0;
  int bad = 0;
  bit done = 1'b0;

  ds_wake_top #(.RST_CYCLES(RST)) dut_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .statusClr(statusClr),
    .porEvent(porEvent), .wdtTimeout(wdtTimeout), .rtcAlarm(rtcAlarm),
    .rtcEnable(rtcEnable), .mclrN(mclrN), .extPin(extPin),
    .extPolarity(extPolarity), .extEnable(extEnable), .brownOut(brownOut),
    .dsEnable(dsEnable), .pendClr(pendClr), .exitFlag(exitFlag),
    .wakeSrc(wakeSrc), .dsBor(dsBor), .coreRst(coreRst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setSrc(input int s, input bit on);
    case (s)
      0: porEvent = on;
      1: wdtTimeout = on;
      2: rtcAlarm = on;
      default: mclrN = !on;
    endcase
  endtask

  task automatic enter();
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    chk("R1 dsEnable after request", dsEnable, 1);
    chk("R1 pendClr at entry", pendClr, 1);
    tick();
    chk("R1 pendClr single cycle", pendClr, 0);
  endtask

  // Called at the negedge after the exit; startLen cycles of coreRst already seen
  task automatic finishRestart(input int startLen);
    int n = startLen;
    for (int i = 0; i < 50; i++) begin
      tick();
      if (!coreRst) break;
      n++;
    end
    chk("R6 reset window length", n, RST);
  endtask

  task automatic clearStatus();
    statusClr = 1'b1;
    tick();
    statusClr = 1'b0;
    chk("R7 exitFlag cleared", exitFlag, 0);
    chk("R7 wakeSrc cleared", wakeSrc, 0);
    chk("R7 dsBor cleared", dsBor, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sleepReq = 1'b0; statusClr = 1'b0; porEvent = 1'b0;
    wdtTimeout = 1'b0; rtcAlarm = 1'b0; rtcEnable = 1'b1; mclrN = 1'b1;
    extPin = 1'b0; extPolarity = 1'b1; extEnable = 1'b0; brownOut = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R9 dsEnable", dsEnable, 0);
    chk("R9 pendClr", pendClr, 0);
    chk("R9 exitFlag", exitFlag, 0);
    chk("R9 wakeSrc", wakeSrc, 0);
    chk("R9 dsBor", dsBor, 0);
    chk("R9 coreRst", coreRst, 0);

    // R2/R5: every non-empty combination of the four level sources
    for (int mask = 1; mask < 16; mask++) begin
      enter();
      for (int s = 0; s < 4; s++) setSrc(s, mask[s]);
      tick();
      for (int s = 0; s < 4; s++) setSrc(s, 1'b0);
      chk("R2 dsEnable self-clears", dsEnable, 0);
      chk("R2 exitFlag set", exitFlag, 1);
      chk("R2 coreRst raised", coreRst, 1);
      chk("R5 wakeSrc record", wakeSrc, mask);
      finishRestart(1);
      repeat (3) tick();
      chk("R7 exitFlag held", exitFlag, 1);
      chk("R7 wakeSrc held", wakeSrc, mask);
      clearStatus();
    end

    // R3: disabled clock alarm, R8: brown-out in sleep
    enter();
    rtcEnable = 1'b0;
    rtcAlarm = 1'b1;
    repeat (4) tick();
    chk("R3 gated alarm no wake", dsEnable, 1);
    rtcAlarm = 1'b0;
    rtcEnable = 1'b1;
    brownOut = 1'b1;
    tick();
    brownOut = 1'b0;
    chk("R8 dsBor in sleep", dsBor, 1);
    chk("R8 brown-out no wake", dsEnable, 1);
    wdtTimeout = 1'b1;
    tick();
    wdtTimeout = 1'b0;
    chk("R5 watchdog record", wakeSrc, 2);
    // R6/R10: events in the reset window are dropped
    porEvent = 1'b1;
    sleepReq = 1'b1;
    tick();
    porEvent = 1'b0;
    sleepReq = 1'b0;
    chk("R6 record unchanged in window", wakeSrc, 2);
    finishRestart(2);
    chk("R10 request in window ignored", dsEnable, 0);
    chk("R7 dsBor held", dsBor, 1);
    clearStatus();
    brownOut = 1'b1;
    tick();
    brownOut = 1'b0;
    tick();
    chk("R8 brown-out awake ignored", dsBor, 0);

    // R4: external pin over polarity, enable and level at entry
    for (int pol = 0; pol < 2; pol++) begin
      for (int en = 0; en < 2; en++) begin
        for (int st = 0; st < 2; st++) begin
          extPolarity = pol[0];
          extPin = st[0] ? pol[0] : !pol[0];
          extEnable = en[0];
          repeat (4) tick();
          enter();
          extEnable = !en[0];
          repeat (4) tick();
          chk("R4 held level no wake", dsEnable, 1);
          if (st != 0) begin
            extPin = !pol[0];
            repeat (4) tick();
            chk("R4 release no wake", dsEnable, 1);
          end
          extPin = pol[0];
          tick();
          tick();
          chk("R4 synchronizer latency", dsEnable, 1);
          tick();
          if (en != 0) begin
            chk("R4 enabled edge wakes", dsEnable, 0);
            chk("R5 external record", wakeSrc, 16);
            finishRestart(1);
          end else begin
            chk("R4 disabled edge ignored", dsEnable, 1);
            wdtTimeout = 1'b1;
            tick();
            wdtTimeout = 1'b0;
            chk("R5 watchdog record", wakeSrc, 2);
            finishRestart(1);
          end
          clearStatus();
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule